// File: doc/BRIEF.md
# Dual-Phase Interleaved DDS Generator

This block is the digital front end of a synthesizer-driven phase rotator. A phase accumulator advances by a frequency control word once per sample period, and two table paths turn that phase into cosine and sine amplitude codes. The main path reads the table at the accumulated phase. The lead path reads it at the accumulated phase plus half the control word. The two paths are refreshed on alternate half-periods and a slot-selected multiplexer interleaves them. The output stream therefore looks like one synthesizer running at twice the sample rate, which cancels the odd image replicas around the sample frequency.

The design runs on one clock at twice the sample rate. An internal slot flag takes the place of the true and complemented sample clocks. Each amplitude code is split into a binary low segment and a thermometer-coded high segment, ready for a segmented current-steering converter. A direction input mirrors the quadrature code so that the same control word gives either a positive or a negative frequency offset. The table is writable through its own port, so pre-distorted values can be loaded while the generator is stopped.

Top module: `dual_phase_dds`

## Requirements
- R1: While rst_n is low, and after it rises, every binary and thermometer output is zero. The accumulator starts at phase zero and the next update is a main-path update.
- R2: While run_en is high, the accumulator advances by fcw, modulo 2^ACC_W, once every two clocks, on the lead-slot clock. On main-slot clocks it keeps its value.
- R3: The lead path reads the table at accumulator + (fcw >> 1), modulo 2^ACC_W, using the accumulator value from before that clock's advance.
- R4: While running, the outputs alternate every clock. Main-path data (the table at the current accumulator) appears first, then lead-path data, then main-path data at the advanced phase, and so on.
- R5: The table address is the top ADDR_W bits of the phase word in use.
- R6: The I outputs come from the cosine column of the addressed entry. The Q outputs come from the sine column.
- R7: When neg_sel is high, the Q code is the bitwise complement of the sine value. The I code is not affected. The effect is immediate and needs no clock.
- R8: For each code, the bin output carries the low BIN_W bits. Thermometer line k (counted from bit 0) is 1 exactly when the high segment, read as unsigned, is greater than k. Codes 8'hFF and 8'h00 give all lines set and all lines clear.
- R9: A table write (tbl_we high) changes the entry at tbl_addr only when run_en is low. Writes made while run_en is high are ignored.
- R10: While run_en is low, the accumulator, slot and outputs hold, including while the table is being loaded.
- R11: A change of fcw never clears the phase. The new word first acts on the next lead-slot clock, starting from the phase already reached.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Runs the generator; low allows table loading |
| fcw | input | ACC_W | Frequency control word |
| neg_sel | input | 1 | Selects a negative frequency offset (complements Q) |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | ADDR_W | Table write address |
| tbl_cos | input | AMP_W | Cosine value to write |
| tbl_sin | input | AMP_W | Sine value to write |
| i_bin | output | BIN_W | I code, binary low segment |
| i_therm | output | 2^(AMP_W-BIN_W)-1 | I code, thermometer high segment |
| q_bin | output | BIN_W | Q code, binary low segment |
| q_therm | output | 2^(AMP_W-BIN_W)-1 | Q code, thermometer high segment |

## Verification
The bench builds the block with ACC_W=8 and ADDR_W=4, and keeps AMP_W=8 and BIN_W=4. With a 16-entry table, one control word of 16 visits every entry in 32 clocks. Odd control words and a word of 255 make the half-word truncation and the accumulator wrap show up within a few samples. The full 8-bit amplitude range is kept, so the all-ones and all-zeros thermometer extremes, and every code in between, can be reached through the table.

// File: rtl/dds_pkg.sv
`timescale 1ns/1ps
package dds_pkg;

    typedef enum logic {
        SLOT_MAIN = 1'b0,
        SLOT_LEAD = 1'b1
    } slot_e;

endpackage

// File: rtl/dds_lut.sv
`timescale 1ns/1ps
module dds_lut #(
    parameter int ADDR_W = 10,
    parameter int AMP_W  = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [AMP_W-1:0]  wr_cos,
    input  logic [AMP_W-1:0]  wr_sin,
    input  logic [ADDR_W-1:0] rd_addr_a,
    output logic [AMP_W-1:0]  rd_cos_a,
    output logic [AMP_W-1:0]  rd_sin_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [AMP_W-1:0]  rd_cos_b,
    output logic [AMP_W-1:0]  rd_sin_b
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [2*AMP_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= {wr_cos, wr_sin};
        end
    end

    always_comb begin
        {rd_cos_a, rd_sin_a} = mem_q[rd_addr_a];
        {rd_cos_b, rd_sin_b} = mem_q[rd_addr_b];
    end

endmodule

// File: rtl/dds_seg.sv
`timescale 1ns/1ps
module dds_seg #(
    parameter int AMP_W = 8,
    parameter int BIN_W = 4
) (
    input  logic [AMP_W-1:0]                     code,
    output logic [BIN_W-1:0]                     bin,
    output logic [(1 << (AMP_W - BIN_W)) - 2:0]  therm
);
    localparam int SEG_W   = AMP_W - BIN_W;
    localparam int THERM_W = (1 << SEG_W) - 1;

    logic [SEG_W-1:0] upper;

    assign bin   = code[BIN_W-1:0];
    assign upper = code[AMP_W-1:BIN_W];

    for (genvar k = 0; k < THERM_W; k++) begin : g_line
        assign therm[k] = (32'(upper) > k);
    end

endmodule

// File: rtl/dual_phase_dds.sv
`timescale 1ns/1ps
module dual_phase_dds
    import dds_pkg::*;
#(
    parameter int ACC_W  = 20,
    parameter int ADDR_W = 10,
    parameter int AMP_W  = 8,
    parameter int BIN_W  = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                run_en,
    input  logic [ACC_W-1:0]                    fcw,
    input  logic                                neg_sel,
    input  logic                                tbl_we,
    input  logic [ADDR_W-1:0]                   tbl_addr,
    input  logic [AMP_W-1:0]                    tbl_cos,
    input  logic [AMP_W-1:0]                    tbl_sin,
    output logic [BIN_W-1:0]                    i_bin,
    output logic [(1 << (AMP_W - BIN_W)) - 2:0] i_therm,
    output logic [BIN_W-1:0]                    q_bin,
    output logic [(1 << (AMP_W - BIN_W)) - 2:0] q_therm
);
    localparam int THERM_W = (1 << (AMP_W - BIN_W)) - 1;

    typedef struct packed {
        logic [AMP_W-1:0] cos_v;
        logic [AMP_W-1:0] sin_v;
    } amp_t;

    typedef struct packed {
        slot_e            slot;
        logic [ACC_W-1:0] acc;
        amp_t             p1;
        amp_t             p2;
    } state_t;

    state_t st_d, st_q;

    logic [ACC_W-1:0]  lead_ph;
    logic [ADDR_W-1:0] main_addr, lead_addr;
    logic [AMP_W-1:0]  main_cos, main_sin, lead_cos, lead_sin;
    logic              load_ok;
    amp_t              sel_amp;
    logic [AMP_W-1:0]  i_code, q_code;

    assign lead_ph   = st_q.acc + (fcw >> 1);
    assign main_addr = st_q.acc[ACC_W-1 -: ADDR_W];
    assign lead_addr = lead_ph[ACC_W-1 -: ADDR_W];
    assign load_ok   = tbl_we && !run_en;

    dds_lut #(
        .ADDR_W (ADDR_W),
        .AMP_W  (AMP_W)
    ) lut_i (
        .clk       (clk),
        .wr_en     (load_ok),
        .wr_addr   (tbl_addr),
        .wr_cos    (tbl_cos),
        .wr_sin    (tbl_sin),
        .rd_addr_a (main_addr),
        .rd_cos_a  (main_cos),
        .rd_sin_a  (main_sin),
        .rd_addr_b (lead_addr),
        .rd_cos_b  (lead_cos),
        .rd_sin_b  (lead_sin)
    );

    always_comb begin
        st_d = st_q;
        if (run_en) begin
            if (st_q.slot == SLOT_MAIN) begin
                st_d.p1.cos_v = main_cos;
                st_d.p1.sin_v = main_sin;
                st_d.slot     = SLOT_LEAD;
            end else begin
                st_d.p2.cos_v = lead_cos;
                st_d.p2.sin_v = lead_sin;
                st_d.acc      = st_q.acc + fcw;
                st_d.slot     = SLOT_MAIN;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        sel_amp = (st_q.slot == SLOT_LEAD) ? st_q.p1 : st_q.p2;
        i_code  = sel_amp.cos_v;
        q_code  = neg_sel ? ~sel_amp.sin_v : sel_amp.sin_v;
    end

    dds_seg #(
        .AMP_W (AMP_W),
        .BIN_W (BIN_W)
    ) i_seg_i (
        .code  (i_code),
        .bin   (i_bin),
        .therm (i_therm)
    );

    dds_seg #(
        .AMP_W (AMP_W),
        .BIN_W (BIN_W)
    ) q_seg_i (
        .code  (q_code),
        .bin   (q_bin),
        .therm (q_therm)
    );

    AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && st_q.slot == SLOT_LEAD) |=> (st_q.acc == $past(st_q.acc) + $past(fcw))); // R2
    AST_ACC_STILL_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && st_q.slot == SLOT_MAIN) |=> $stable(st_q.acc)); // R2
    AST_SLOT_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> (st_q.slot != $past(st_q.slot))); // R4
    AST_MAIN_HOLD_IN_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && st_q.slot == SLOT_LEAD) |=> $stable(st_q.p1)); // R4
    AST_ACC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> ($stable(st_q.acc) && $stable(st_q.slot))); // R10
    AST_I_OUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> ($stable(i_bin) && $stable(i_therm))); // R10

    initial begin
        assert (THERM_W >= 1 && ADDR_W <= ACC_W);
    end

endmodule

// File: tb/dual_phase_dds_tb_top.sv
`timescale 1ns/1ps
module dual_phase_dds_tb_top;

    localparam int ACC_W  = 8;
    localparam int ADDR_W = 4;
    localparam int AMP_W  = 8;
    localparam int BIN_W  = 4;
    localparam int DEPTH  = 1 << ADDR_W;

    // stimulus vectors: {neg_sel, fcw}
    localparam int NVEC = 6;
    localparam logic [8:0] VEC [NVEC] = '{
        9'h010, 9'h025, 9'h1C8, 9'h0FF, 9'h101, 9'h080
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             run_en = 1'b0;
    logic [ACC_W-1:0] fcw = '0;
    logic             neg_sel = 1'b0;
    logic             tbl_we = 1'b0;
    logic [ADDR_W-1:0] tbl_addr = '0;
    logic [AMP_W-1:0] tbl_cos = '0;
    logic [AMP_W-1:0] tbl_sin = '0;
    logic [BIN_W-1:0] i_bin, q_bin;
    logic [14:0]      i_therm, q_therm;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] mc [DEPTH];
    logic [7:0] ms [DEPTH];
    logic [7:0] acc_m = '0;
    bit         slot_m = 1'b0;
    logic [7:0] exp_c = '0;
    logic [7:0] exp_s = '0;

    always #2 clk = ~clk;

    dual_phase_dds #(
        .ACC_W (ACC_W), .ADDR_W (ADDR_W), .AMP_W (AMP_W), .BIN_W (BIN_W)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .run_en (run_en), .fcw (fcw),
        .neg_sel (neg_sel), .tbl_we (tbl_we), .tbl_addr (tbl_addr),
        .tbl_cos (tbl_cos), .tbl_sin (tbl_sin),
        .i_bin (i_bin), .i_therm (i_therm), .q_bin (q_bin), .q_therm (q_therm)
    );

    function automatic logic [14:0] therm_of(input logic [3:0] u);
        logic [15:0] t;
        t = (16'd1 << u) - 16'd1;
        return t[14:0];
    endfunction

    task automatic check(input string tag);
        logic [7:0] qe;
        qe = neg_sel ? ~exp_s : exp_s;
        checks++;
        if (i_bin !== exp_c[3:0] || i_therm !== therm_of(exp_c[7:4]) ||
            q_bin !== qe[3:0] || q_therm !== therm_of(qe[7:4])) begin
            errors++;
            $display("FAIL %s: got i=%h/%h q=%h/%h exp i=%h/%h q=%h/%h", tag,
                     i_bin, i_therm, q_bin, q_therm,
                     exp_c[3:0], therm_of(exp_c[7:4]), qe[3:0], therm_of(qe[7:4]));
        end
    endtask

    // one clock edge, model update, check away from the edge
    task automatic step(input string tag);
        logic [7:0] ph;
        @(posedge clk);
        #1;
        if (!rst_n) begin
            acc_m = '0; slot_m = 1'b0; exp_c = '0; exp_s = '0;
        end else if (run_en) begin
            if (!slot_m) begin
                exp_c = mc[acc_m[7:4]];
                exp_s = ms[acc_m[7:4]];
                slot_m = 1'b1;
            end else begin
                ph = acc_m + (fcw >> 1);
                exp_c = mc[ph[7:4]];
                exp_s = ms[ph[7:4]];
                acc_m = acc_m + fcw;
                slot_m = 1'b0;
            end
        end
        check(tag);
    endtask

    initial begin
        repeat (3) step("R1 reset held");
        rst_n = 1'b1;
        step("R1 after reset");

        // load table while stopped
        for (int a = 0; a < DEPTH; a++) begin
            tbl_we = 1'b1; tbl_addr = 4'(a);
            tbl_cos = 8'((a * 37 + 5) & 255);
            tbl_sin = 8'((a * 91 + 200) & 255);
            mc[a] = tbl_cos; ms[a] = tbl_sin;
            step("R10 R9 hold while loading");
        end
        tbl_we = 1'b0;

        // vector table walk: accumulator runs on across fcw changes (R11)
        run_en = 1'b1;
        for (int v = 0; v < NVEC; v++) begin
            fcw = VEC[v][7:0];
            neg_sel = VEC[v][8];
            for (int s = 0; s < 7; s++) step("R2 R3 R4 R5 R6 R7 R11");
        end

        // neg_sel acts at once, I untouched
        neg_sel = ~neg_sel;
        #1 check("R7 immediate direction flip");
        neg_sel = 1'b0;
        #1 check("R7 direction restored");

        // stop: everything holds
        run_en = 1'b0;
        for (int s = 0; s < 3; s++) step("R10 stopped hold");

        // writes while running are ignored
        run_en = 1'b1; fcw = 8'd16;
        for (int a = 0; a < DEPTH; a++) begin
            tbl_we = 1'b1; tbl_addr = 4'(a); tbl_cos = 8'h5A; tbl_sin = 8'hA5;
            step("R9 write ignored while running");
        end
        tbl_we = 1'b0;
        for (int s = 0; s < 2 * DEPTH; s++) step("R9 table unchanged");

        // reload full-range table while stopped
        run_en = 1'b0;
        for (int a = 0; a < DEPTH; a++) begin
            tbl_we = 1'b1; tbl_addr = 4'(a);
            tbl_cos = 8'(a * 17);
            tbl_sin = 8'(255 - a * 17);
            mc[a] = tbl_cos; ms[a] = tbl_sin;
            step("R9 R10 reload hold");
        end
        tbl_we = 1'b0;
        run_en = 1'b1; fcw = 8'd16;
        for (int s = 0; s < 2 * DEPTH + 2; s++) step("R8 R9 full range codes");

        // reset in mid-run restarts from phase zero
        rst_n = 1'b0;
        step("R1 reset mid-run");
        rst_n = 1'b1;
        fcw = 8'd37;
        for (int s = 0; s < 6; s++) step("R1 R2 restart from zero");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hang exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule